// File: doc/BRIEF.md
# Vectored Interrupt Controller with Acknowledge

The block gathers fifteen on-chip event sources and up to sixteen external interrupt inputs into one sticky 32-bit status word. An enable register masks that word to form a live pending word, and a single request line goes high whenever any pending bit is set. Software clears events by writing ones to a clear register. Writing a zero leaves the matching bit alone.

When built with fast handling, a mode register selects the sources that are served through vectors. Among the pending sources that are selected, the lowest-numbered one wins. Its entry from a 32-entry vector table is driven on an address output next to the request. The processor answers on a two-bit acknowledge input, and the "taken" code clears the status bit of that winner. Register access uses a plain write strobe and a word index. Read data comes back combinationally from the same index. The block has no streaming data path, so it has no valid/ready handshake.

Top module: `irqv_ctrl`

## Requirements
- R1: After reset the status word, the pending word, `irq` and `irq_addr` are all 0.
- R2: A 1 on an event input sets its status bit on the next clock edge, and the bit stays set until cleared. The mapping is: `int_evt[14:0]` to status bits 14..0, where bit 0 is the serial error, bit 1 is transmit done, bit 2 is receive data, bits 3–6 are the programmable timers, bits 7–10 are the fixed timers and bits 11–14 are the input-change events. `ext_evt[k]` maps to bit 16+k. Bit 15, and any bit above 16+EXT_NUM-1, always reads 0. Index 0 reads the status word.
- R3: Index 1 reads the pending word, which equals status AND enable. Index 2 writes the enable register.
- R4: `irq` is 1 exactly when the pending word is nonzero.
- R5: A write to index 3 clears every status bit whose data bit is 1 and leaves the bits written with 0 unchanged.
- R6: An event that arrives in the same cycle as a clear of its bit leaves that status bit set. This holds for a register clear and for a vectored acknowledge.
- R7: Index 4 writes the mode register, and indices 32+k write vector k. `irq_addr` carries the vector of the lowest-numbered bit of (pending AND mode), or 0 when that word is 0.
- R8: `irq_ack` = 2'b01 clears the status bit of the current vectored winner on the next edge. The codes 2'b00, 2'b10 and 2'b11 have no effect.
- R9: Reads of the write-only indices (2, 3, 4, 32–63) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Word index for both write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| int_evt | input | 15 | On-chip event pulses |
| ext_evt | input | EXT_NUM | External interrupt inputs |
| irq | output | 1 | Interrupt request |
| irq_addr | output | ADDR_W | Vector of the winning fast source |
| irq_ack | input | 2 | Acknowledge code from the processor |

## Verification
The assertions assume that the event and acknowledge inputs are known after reset, and that the acknowledge code changes only between clock edges. The bench drives every input on the falling edge and holds each pulse for exactly one cycle. It issues one register write per cycle, so the clear and the event paths meet only in the cycles the bench chooses on purpose for R6. It also sweeps every mapped source through set, clear and vectored acknowledge.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int ST_W      = 32;
  localparam int INT_SRC   = 15;
  localparam int EXT_BASE  = 16;
  localparam int IDX_W     = 6;
  localparam logic [IDX_W-1:0] IDX_STATUS = 6'd0;
  localparam logic [IDX_W-1:0] IDX_PEND   = 6'd1;
  localparam logic [IDX_W-1:0] IDX_ENABLE = 6'd2;
  localparam logic [IDX_W-1:0] IDX_CLEAR  = 6'd3;
  localparam logic [IDX_W-1:0] IDX_MODE   = 6'd4;
  localparam logic [1:0]       ACK_TAKEN  = 2'b01;
endpackage

// File: rtl/irqv_status.sv
module irqv_status
  import irqv_pkg::*;
#(
  parameter int EXT_NUM = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] evt_set,
  input  logic [ST_W-1:0] clr,
  input  logic            en_wr,
  input  logic [ST_W-1:0] en_data,
  output logic [ST_W-1:0] status,
  output logic [ST_W-1:0] pending
);
  localparam logic [ST_W-1:0] EXT_MASK = ((32'd1 << EXT_NUM) - 32'd1) << EXT_BASE;
  localparam logic [ST_W-1:0] VALID    = EXT_MASK | 32'h0000_7FFF;

  logic [ST_W-1:0] enable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= ((status & ~clr) | evt_set) & VALID;
      if (en_wr) enable <= en_data & VALID;
    end
  end

  assign pending = status & enable;

  // R2
  status_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(evt_set)) == '0));
  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |=> ((status & $past(clr & ~evt_set)) == '0));
  // R6
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_set & VALID) != '0) |=> ((status & $past(evt_set & VALID)) == $past(evt_set & VALID)));
endmodule

// File: rtl/irqv_vector.sv
module irqv_vector
  import irqv_pkg::*;
#(
  parameter int HAS_FAST = 1,
  parameter int ADDR_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [IDX_W-1:0]  reg_addr,
  input  logic [ST_W-1:0]   reg_wdata,
  input  logic [ST_W-1:0]   pending,
  input  logic [1:0]        irq_ack,
  output logic [ST_W-1:0]   win_oh,
  output logic [ST_W-1:0]   fast_clr,
  output logic [ADDR_W-1:0] irq_addr
);
  localparam int SEL_W = $clog2(ST_W);

  generate
    if (HAS_FAST != 0) begin : g_fast
      logic [ST_W-1:0]   mode;
      logic [ADDR_W-1:0] vec [ST_W];
      logic [ST_W-1:0]   cand;
      logic [SEL_W-1:0]  sel;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          mode <= '0;
          for (int i = 0; i < ST_W; i++) vec[i] <= '0;
        end else if (reg_wr) begin
          if (reg_addr == IDX_MODE) mode <= reg_wdata;
          if (reg_addr[IDX_W-1]) vec[reg_addr[SEL_W-1:0]] <= reg_wdata[ADDR_W-1:0];
        end
      end

      assign cand = pending & mode;

      always_comb begin
        sel = '0;
        for (int i = ST_W - 1; i >= 0; i--) if (cand[i]) sel = SEL_W'(i);
      end

      assign win_oh   = (cand != '0) ? (ST_W'(1) << sel) : '0;
      assign irq_addr = (cand != '0) ? vec[sel] : '0;
      assign fast_clr = (irq_ack == ACK_TAKEN) ? win_oh : '0;

      // R7
      winner_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_oh) && ((win_oh & ~cand) == '0) && ((cand & (win_oh - 1'b1)) == '0));
    end else begin : g_plain
      assign win_oh   = '0;
      assign irq_addr = '0;
      assign fast_clr = '0;
    end
  endgenerate
endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
  import irqv_pkg::*;
#(
  parameter int EXT_NUM  = 16,
  parameter int ADDR_W   = 32,
  parameter int HAS_FAST = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [5:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [14:0]        int_evt,
  input  logic [EXT_NUM-1:0] ext_evt,
  output logic               irq,
  output logic [ADDR_W-1:0]  irq_addr,
  input  logic [1:0]         irq_ack
);
  logic [ST_W-1:0] evt_set, clr, status, pending, win_oh, fast_clr, wr_clr;

  always_comb begin
    evt_set = '0;
    evt_set[INT_SRC-1:0] = int_evt;
    evt_set[EXT_BASE +: EXT_NUM] = ext_evt;
  end

  assign wr_clr = (reg_wr && reg_addr == IDX_CLEAR) ? reg_wdata : '0;
  assign clr    = wr_clr | fast_clr;

  irqv_status #(.EXT_NUM(EXT_NUM)) i_status (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .clr(clr),
    .en_wr(reg_wr && reg_addr == IDX_ENABLE), .en_data(reg_wdata),
    .status(status), .pending(pending)
  );

  irqv_vector #(.HAS_FAST(HAS_FAST), .ADDR_W(ADDR_W)) i_vector (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pending(pending), .irq_ack(irq_ack),
    .win_oh(win_oh), .fast_clr(fast_clr), .irq_addr(irq_addr)
  );

  assign irq = |pending;

  always_comb begin
    unique case (reg_addr)
      IDX_STATUS: reg_rdata = status;
      IDX_PEND:   reg_rdata = pending;
      default:    reg_rdata = '0;
    endcase
  end

  // R8
  ack_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack == ACK_TAKEN && win_oh != '0) |=> ((status & $past(win_oh & ~evt_set)) == '0));
  // R4
  irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != '0));
endmodule

// File: tb/test_irqv_ctrl.sv
module test_irqv_ctrl;
  localparam int EXT_NUM = 16;
  localparam int ADDR_W  = 16;
  localparam logic [31:0] VALID = 32'hFFFF_7FFF;

  logic clk = 0, rst_n = 0, reg_wr = 0, irq;
  logic [5:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [14:0] int_evt = 0;
  logic [EXT_NUM-1:0] ext_evt = 0;
  logic [ADDR_W-1:0] irq_addr;
  logic [1:0] irq_ack = 0;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  irqv_ctrl #(.EXT_NUM(EXT_NUM), .ADDR_W(ADDR_W), .HAS_FAST(1)) i_irqv_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .int_evt(int_evt),
    .ext_evt(ext_evt), .irq(irq), .irq_addr(irq_addr), .irq_ack(irq_ack));

  function automatic logic [ADDR_W-1:0] vec_val(int k);
    return ADDR_W'(16'h1000 + k * 16'h0011);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_addr = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata; reg_addr = 0;
  endtask

  task automatic pulse(logic [31:0] m);
    int_evt = m[14:0]; ext_evt = m[31:16];
    @(negedge clk);
    int_evt = 0; ext_evt = 0;
  endtask

  initial begin
    #2_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] st;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    rd(0, d); chk("R1 status", d, 0);
    rd(1, d); chk("R1 pending", d, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 irq_addr", {16'd0, irq_addr}, 0);

    // R2 / R5: each source alone, set then clear
    for (int b = 0; b < 32; b++) begin
      if (b == 15) continue;
      pulse(32'd1 << b);
      rd(0, d); chk("R2 set", d, 32'd1 << b);
      @(negedge clk);
      rd(0, d); chk("R2 sticky", d, 32'd1 << b);
      wr(3, 32'd1 << b);
      rd(0, d); chk("R5 clear", d, 0);
    end
    // R2: no input reaches bit 15
    pulse(32'hFFFF_FFFF);
    rd(0, d); chk("R2 reserved bit", d, VALID);

    // R5: zeros leave bits, partial clear
    wr(3, 32'h0);
    rd(0, d); chk("R5 zero write", d, VALID);
    wr(3, 32'h00F0_00F0);
    rd(0, d); chk("R5 partial", d, VALID & ~32'h00F0_00F0);
    wr(3, 32'hFFFF_FFFF);

    // R3 / R4: enable patterns
    st = 32'hA5A5_1234 & VALID;
    pulse(st);
    for (int p = 0; p < 8; p++) begin
      logic [31:0] en;
      en = 32'h1 << (p * 4 + 1) | (32'h3 << (p * 3));
      wr(2, en);
      rd(1, d); chk("R3 pending", d, st & en);
      chk("R4 irq", {31'd0, irq}, {31'd0, (st & en) != 0});
    end
    wr(2, 32'h0);
    chk("R4 irq off", {31'd0, irq}, 0);
    wr(2, 32'hFFFF_FFFF);
    wr(3, 32'hFFFF_FFFF);
    chk("R4 irq cleared", {31'd0, irq}, 0);

    // R6: event in same cycle as clear
    pulse(32'h0001_0004);
    reg_wr = 1; reg_addr = 3; reg_wdata = 32'h0001_0004; int_evt = 15'h4;
    @(negedge clk);
    reg_wr = 0; reg_addr = 0; int_evt = 0;
    rd(0, d); chk("R6 event beats clear", d, 32'h0000_0004);
    wr(3, 32'hFFFF_FFFF);

    // R9: write-only indices read zero
    rd(2, d); chk("R9 enable reads 0", d, 0);
    rd(4, d); chk("R9 mode reads 0", d, 0);
    rd(40, d); chk("R9 vector reads 0", d, 0);

    // R7: vectors and mode
    for (int k = 0; k < 32; k++) wr(6'(32 + k), {16'd0, vec_val(k)});
    pulse(VALID);
    chk("R7 no mode", {16'd0, irq_addr}, 0);
    wr(4, 32'd1 << 20);
    chk("R7 single fast", {16'd0, irq_addr}, {16'd0, vec_val(20)});
    wr(4, 32'hFFFF_FFFF);
    // R8: other codes ignored
    for (int c = 0; c < 4; c++) begin
      if (c == 1) continue;
      irq_ack = 2'(c); @(negedge clk); irq_ack = 0;
      rd(0, d); chk("R8 ignored code", d, VALID);
    end
    // R7 / R8: sweep winners in order
    st = VALID;
    for (int b = 0; b < 32; b++) begin
      if (b == 15) continue;
      chk("R7 winner vector", {16'd0, irq_addr}, {16'd0, vec_val(b)});
      irq_ack = 2'b01; @(negedge clk); irq_ack = 0;
      st[b] = 1'b0;
      rd(0, d); chk("R8 taken clears", d, st);
    end
    chk("R8 all served irq", {31'd0, irq}, 0);

    // R6: event on the winner while taken
    pulse(32'h0000_0020);
    int_evt = 15'h20; irq_ack = 2'b01;
    @(negedge clk);
    int_evt = 0; irq_ack = 0;
    rd(0, d); chk("R6 event beats ack", d, 32'h20);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule